// File: doc/BRIEF.md
# Masked vector find-first-set unit

This block serves the scalar-result mask instruction of a vector processor that reports where the first set mask bit lies. It takes two vector register images: the source mask and the v0 mask. It also takes the active vector length, a log2-encoded element stride, and the instruction word. From these it returns the index of the lowest active element whose source mask bit is set. When no such element exists, it returns a value with every bit set across the full scalar width.

A small decoder checks the instruction word and breaks out the destination index, the source register index and the vm flag. When the word matches and `start` is pulsed, the result is registered and `done` pulses in the following cycle. The result then holds until the next accepted operation.

Top module: `vmask_ffs_top`

## Requirements
- R1: `decode_hit` is 1 exactly when insn[31:26]=010101, insn[14:12]=010 and insn[6:0]=1010111. `vm_flag`=insn[25], `vs2_idx`=insn[24:20] and `rd_idx`=insn[11:7]. insn[19:15] has no effect on any output.
- R2: When `start` is high with `decode_hit` high in cycle k, `done` is high in cycle k+1 only. A `start` with `decode_hit` low raises no `done`.
- R3: An element whose index is at or above the effective vector length never produces the result.
- R4: With vm=1, every element below the effective length is active. With vm=0, element i is active only when its v0 mask bit is set.
- R5: The result is the smallest active index whose source mask bit is set, zero-extended to XLEN bits.
- R6: When no active element has its source bit set (including vl=0), the result is all ones across XLEN bits.
- R7: The mask bit of element i lies at bit i<<s of both v0 and the source image, where s is `mlen_log2`. A value of s above LOG2_MAX (6 by default) acts as LOG2_MAX.
- R8: The effective vector length is min(vl, VLEN>>s).
- R9: A synchronous active-low reset clears `done` and `result` to zero.
- R10: `result` stays unchanged in every cycle that does not follow an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request; all operands are valid with it |
| insn | input | 32 | Instruction word |
| src_mask | input | VLEN | Source mask register image |
| v0_mask | input | VLEN | v0 mask register image |
| vl | input | VL_W | Active vector length, 0..VLEN |
| mlen_log2 | input | ML_W | log2 of the mask element stride |
| decode_hit | output | 1 | Instruction word matches |
| rd_idx | output | 5 | Destination register field |
| vs2_idx | output | 5 | Source register field |
| vm_flag | output | 1 | Unmasked-operation flag |
| done | output | 1 | Result valid pulse |
| result | output | XLEN | Found index, or all ones |

## Verification
The bench builds the block with its defaults: VLEN=128, XLEN=64 and LOG2_MAX=6. With these values, every stride from 1 to 64 leaves between 128 and 2 elements. As a result, a vl above the clamped length can be reached at every stride except 1, and bits lying between element positions are present to be ignored. An XLEN of 64 makes the all-ones miss value much wider than the 7-bit index, so a partly extended miss value shows up in the checks.

// File: rtl/vffs_pkg.sv
`timescale 1ns/1ps
// vffs_pkg: instruction field constants shared by the find-first-set unit.
// Assumes the 32-bit vector instruction layout with fixed opcode fields.
package vffs_pkg;
    localparam logic [5:0] FFS_FUNCT6 = 6'b010101;
    localparam logic [2:0] FFS_FUNCT3 = 3'b010;
    localparam logic [6:0] FFS_OPCODE = 7'b1010111;
endpackage

// File: rtl/vffs_decode.sv
`timescale 1ns/1ps
// vffs_decode: recognises the find-first-set instruction word and breaks
// out its register and vm fields. Purely combinational; bits [19:15] unused.
module vffs_decode
    import vffs_pkg::*;
(
    input  logic [31:0] insn,
    output logic        hit,
    output logic [4:0]  rd,
    output logic [4:0]  vs2,
    output logic        vm
);
    // Match the three fixed fields and extract the operand fields.
    always_comb begin
        hit = (insn[31:26] == FFS_FUNCT6) && (insn[14:12] == FFS_FUNCT3) &&
              (insn[6:0] == FFS_OPCODE);
        vm  = insn[25];
        vs2 = insn[24:20];
        rd  = insn[11:7];
    end
endmodule

// File: rtl/vffs_gather.sv
`timescale 1ns/1ps
// vffs_gather: builds one bit per element that is set when the element is
// below the clamped vector length, active, and set in the source mask.
// Assumes the element mask bit lies at position i<<stride in both images.
module vffs_gather #(
    parameter int VLEN     = 128,
    parameter int LOG2_MAX = 6,
    parameter int ML_W     = 3,
    parameter int VL_W     = 8
) (
    input  logic [VLEN-1:0] src,
    input  logic [VLEN-1:0] v0,
    input  logic            vm,
    input  logic [VL_W-1:0] vl,
    input  logic [ML_W-1:0] mlen_log2,
    output logic [VLEN-1:0] elem_vec,
    output logic [VL_W-1:0] vl_eff
);
    localparam int NV = LOG2_MAX + 1;

    logic [ML_W-1:0]         lg_eff;
    logic [VL_W-1:0]         vlmax;
    logic [NV-1:0][VLEN-1:0] cand;
    logic [VLEN-1:0]         lim;

    // Saturate the stride code and clamp the vector length.
    always_comb begin
        lg_eff = (mlen_log2 > ML_W'(LOG2_MAX)) ? ML_W'(LOG2_MAX) : mlen_log2;
        vlmax  = VL_W'(VLEN >> lg_eff);
        vl_eff = (vl > vlmax) ? vlmax : vl;
    end

    // One candidate element vector per supported stride.
    for (genvar k = 0; k < NV; k++) begin : g_stride
        for (genvar i = 0; i < VLEN; i++) begin : g_elem
            if (i < (VLEN >> k)) begin : g_live
                assign cand[k][i] = src[i << k] & (vm | v0[i << k]);
            end else begin : g_dead
                assign cand[k][i] = 1'b0;
            end
        end
    end

    // Per-element length limit.
    for (genvar i = 0; i < VLEN; i++) begin : g_lim
        assign lim[i] = (VL_W'(i) < vl_eff);
    end

    // Pick the stride variant and apply the length limit.
    always_comb elem_vec = cand[lg_eff] & lim;
endmodule

// File: rtl/vffs_prio.sv
`timescale 1ns/1ps
// vffs_prio: lowest-index priority encoder over the element vector.
// Assumes IDX_W is wide enough to hold VLEN-1.
module vffs_prio #(
    parameter int VLEN  = 128,
    parameter int IDX_W = 7
) (
    input  logic [VLEN-1:0]  vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so the lowest set bit is the one that remains.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = VLEN - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vmask_ffs_top.sv
`timescale 1ns/1ps
// vmask_ffs_top: masked vector find-first-set unit. It decodes the word,
// searches the active elements and registers the scalar result with a
// one-cycle done pulse. Assumes start is a single-cycle pulse and that the
// operands are valid with it.
module vmask_ffs_top #(
    parameter int VLEN     = 128,
    parameter int XLEN     = 64,
    parameter int LOG2_MAX = 6,
    parameter int VL_W     = $clog2(VLEN + 1),
    parameter int ML_W     = $clog2(LOG2_MAX + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [31:0]     insn,
    input  logic [VLEN-1:0] src_mask,
    input  logic [VLEN-1:0] v0_mask,
    input  logic [VL_W-1:0] vl,
    input  logic [ML_W-1:0] mlen_log2,
    output logic            decode_hit,
    output logic [4:0]      rd_idx,
    output logic [4:0]      vs2_idx,
    output logic            vm_flag,
    output logic            done,
    output logic [XLEN-1:0] result
);
    localparam int IDX_W = $clog2(VLEN);

    logic [VLEN-1:0]  elem_vec;
    logic [VL_W-1:0]  vl_eff;
    logic             found;
    logic [IDX_W-1:0] idx;
    logic             accept;

    vffs_decode u_dec (
        .insn (insn),
        .hit  (decode_hit),
        .rd   (rd_idx),
        .vs2  (vs2_idx),
        .vm   (vm_flag)
    );

    vffs_gather #(.VLEN(VLEN), .LOG2_MAX(LOG2_MAX), .ML_W(ML_W), .VL_W(VL_W)) u_gat (
        .src       (src_mask),
        .v0        (v0_mask),
        .vm        (vm_flag),
        .vl        (vl),
        .mlen_log2 (mlen_log2),
        .elem_vec  (elem_vec),
        .vl_eff    (vl_eff)
    );

    vffs_prio #(.VLEN(VLEN), .IDX_W(IDX_W)) u_pri (
        .vec   (elem_vec),
        .found (found),
        .idx   (idx)
    );

    // An operation is accepted only for a matching word.
    always_comb accept = start & decode_hit;

    // Register the done pulse and the result; the result holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= accept;
            if (accept) begin
                result <= found ? {{(XLEN-IDX_W){1'b0}}, idx} : '1;
            end
        end
    end

    // R2: done follows an accepted start, and nothing else.
    p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> done);
    p_no_done_without_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !done);
    // R10: the result holds unless an operation was accepted.
    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(result));
    // R3: no element at or above the effective length is a candidate.
    p_beyond_vl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_vec >> vl_eff) == '0);
    // R8: the clamp never raises the length.
    p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vl_eff <= vl);
    // R5: the encoder points at a set bit with nothing set below it.
    p_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (elem_vec[idx] && ((elem_vec & ((VLEN'(1) << idx) - VLEN'(1))) == '0)));
endmodule

// File: tb/vmask_ffs_top_tb_top.sv
`timescale 1ns/1ps
module vmask_ffs_top_tb_top;
    localparam int VLEN     = 128;
    localparam int XLEN     = 64;
    localparam int LOG2_MAX = 6;
    localparam int VL_W     = $clog2(VLEN + 1);
    localparam int ML_W     = $clog2(LOG2_MAX + 2);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [31:0]     insn = '0;
    logic [VLEN-1:0] src_mask = '0;
    logic [VLEN-1:0] v0_mask = '0;
    logic [VL_W-1:0] vl = '0;
    logic [ML_W-1:0] mlen_log2 = '0;
    logic            decode_hit;
    logic [4:0]      rd_idx;
    logic [4:0]      vs2_idx;
    logic            vm_flag;
    logic            done;
    logic [XLEN-1:0] result;

    int checks = 0;
    int errors = 0;
    logic [XLEN-1:0] last_exp;

    vmask_ffs_top #(.VLEN(VLEN), .XLEN(XLEN), .LOG2_MAX(LOG2_MAX)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .insn(insn),
        .src_mask(src_mask), .v0_mask(v0_mask), .vl(vl), .mlen_log2(mlen_log2),
        .decode_hit(decode_hit), .rd_idx(rd_idx), .vs2_idx(vs2_idx),
        .vm_flag(vm_flag), .done(done), .result(result)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_insn(input logic vmb, input logic [4:0] rd,
                                            input logic [4:0] vs2, input logic [4:0] junk);
        return {6'b010101, vmb, vs2, junk, 3'b010, rd, 7'b1010111};
    endfunction

    // Loop model written from R3..R8.
    function automatic logic [XLEN-1:0] model(input logic [VLEN-1:0] s, input logic [VLEN-1:0] m,
                                              input int len, input int lg, input logic vmb);
        int lge = (lg > LOG2_MAX) ? LOG2_MAX : lg;
        int vmax = VLEN >> lge;
        int eff = (len > vmax) ? vmax : len;
        for (int i = 0; i < eff; i++) begin
            if ((vmb || m[i << lge]) && s[i << lge]) return XLEN'(i);
        end
        return '1;
    endfunction

    task automatic run_op(input logic [VLEN-1:0] s, input logic [VLEN-1:0] m, input int len,
                          input int lg, input logic vmb, input string req);
        logic [XLEN-1:0] exp;
        @(negedge clk);
        src_mask = s; v0_mask = m; vl = VL_W'(len); mlen_log2 = ML_W'(lg);
        insn = mk_insn(vmb, 5'd3, 5'd9, 5'(len));
        start = 1'b1;
        exp = model(s, m, len, lg, vmb);
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b1, "R2 done pulse", XLEN'(done), 1);
        chk(result === exp, req, result, exp);
        @(negedge clk);
        chk(done === 1'b0, "R2 single pulse", XLEN'(done), 0);
        chk(result === exp, "R10 hold", result, exp);
        last_exp = exp;
    endtask

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog R2 actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [VLEN-1:0] one = VLEN'(1);
        void'($urandom(32'd20240611));
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(done === 1'b0, "R9 done reset", XLEN'(done), 0);
        chk(result === '0, "R9 result reset", result, 0);
        rst_n = 1'b1;

        // R1: decode and field extraction; bits [19:15] ignored
        @(negedge clk);
        insn = {6'b010101, 1'b1, 5'd17, 5'b10101, 3'b010, 5'd22, 7'b1010111};
        #1;
        chk(decode_hit === 1'b1, "R1 hit", XLEN'(decode_hit), 1);
        chk(rd_idx === 5'd22, "R1 rd", XLEN'(rd_idx), 22);
        chk(vs2_idx === 5'd17, "R1 vs2", XLEN'(vs2_idx), 17);
        chk(vm_flag === 1'b1, "R1 vm", XLEN'(vm_flag), 1);
        insn[19:15] = 5'b01010;
        #1;
        chk(decode_hit === 1'b1 && rd_idx === 5'd22 && vs2_idx === 5'd17,
            "R1 bits 19:15 ignored", XLEN'(decode_hit), 1);
        insn[31:26] = 6'b010100;
        #1;
        chk(decode_hit === 1'b0, "R1 funct6 miss", XLEN'(decode_hit), 0);
        insn = mk_insn(1'b1, 5'd1, 5'd2, 5'd0); insn[13] = 1'b0;
        #1;
        chk(decode_hit === 1'b0, "R1 funct3 miss", XLEN'(decode_hit), 0);
        insn = mk_insn(1'b1, 5'd1, 5'd2, 5'd0); insn[0] = 1'b0;
        #1;
        chk(decode_hit === 1'b0, "R1 opcode miss", XLEN'(decode_hit), 0);

        // Directed corners
        run_op('1, '1, 0, 0, 1'b1, "R6 vl zero gives all ones");
        run_op('1, '0, 17, 0, 1'b1, "R5 match at index 0");
        run_op(one << 9, '0, 10, 0, 1'b1, "R3 match at last active index");
        run_op(one << 10, '0, 10, 0, 1'b1, "R3 bit at vl ignored");
        run_op('1, '0, 64, 0, 1'b0, "R4 all masked off");
        run_op((one << 3) | (one << 5), one << 5, 64, 0, 1'b0, "R4 v0 selects element 5");
        run_op(one << 16, '0, 16, 3, 1'b1, "R7 stride 8 element 2");
        run_op(one << 17, '1, 16, 3, 1'b1, "R7 unaligned bit ignored");
        run_op(one << 127, '0, 128, 0, 1'b1, "R5 top element");
        run_op(one << 126, '0, 100, 1, 1'b1, "R8 clamp stride 2");
        run_op(one << 64, '0, 128, 6, 1'b1, "R8 clamp stride 64");
        run_op(one << 64, '0, 128, 7, 1'b1, "R7 stride code saturates");

        // R2/R10: a start with a non-matching word is not accepted
        @(negedge clk);
        insn = mk_insn(1'b1, 5'd0, 5'd0, 5'd0); insn[31] = 1'b1;
        src_mask = '1; vl = VL_W'(5); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b0, "R2 no done on miss", XLEN'(done), 0);
        chk(result === last_exp, "R10 hold on miss", result, last_exp);

        // Random: every stride, constrained sparse masks
        for (int lg = 0; lg <= LOG2_MAX; lg++) begin
            for (int n = 0; n < 30; n++) begin
                logic [VLEN-1:0] s, m;
                for (int w = 0; w < VLEN / 32; w++) begin
                    s[w*32 +: 32] = $urandom & $urandom & $urandom & $urandom;
                    m[w*32 +: 32] = $urandom;
                end
                run_op(s, m, int'($urandom_range(0, VLEN)), lg, 1'($urandom), "R5 random search");
            end
        end

        // R9: reset in mid-run clears the registers
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(done === 1'b0 && result === '0, "R9 reset clears result", result, 0);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule